// File: doc/BRIEF.md
# Six-and-Two Sector Stream Encoder

This block turns one 256-byte disk sector into the self-synchronising byte stream a floppy read head would deliver for it. The host writes the sector's 256 bytes into an internal buffer through a simple byte-write port. It then pulses `start` with the track number, the physical sector number, and a flag that asks for the track's leading sync gap. The block emits the optional gap, a 21-byte address header, 343 translated data bytes and a 48-byte trailer on a valid/ready byte stream, at up to one byte per clock.

The data bytes come from a six-and-two split. Bits 1:0 of the source bytes are gathered into 86 auxiliary values, followed by the 256 source bytes. Consecutive values are combined by XOR, with one extra checksum entry at the end. Each result is mapped through a 64-entry table of legal disk bytes. A combinational helper output gives the DOS-order logical sector for a physical sector number, so the host knows which logical sector to load for each physical slot.

Back-pressure rules: `out_valid` stays high from the cycle after an accepted `start` until the last trailer byte is taken. A byte is consumed only in a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_data` holds its value. While `busy` is high, buffer writes and further `start` pulses are ignored.

Top module: `nib_sector_stream`

## Requirements
- R1: After reset, `busy` and `out_valid` are 0.
- R2: When idle, `wr_en` stores `wr_data` at `wr_addr`. A `start` accepted while idle raises `busy` and `out_valid` in the next cycle.
- R3: While `busy` is high, `wr_en` and `start` have no effect: the buffer contents and the latched track and sector used by the stream do not change.
- R4: While `out_valid` is high and `out_ready` is low, `out_data` holds its value and the stream does not advance. A byte is consumed only when both are high.
- R5: With `with_gap`=1 the stream begins with 64 bytes of 0xFF. With `with_gap`=0 it begins directly with the header.
- R6: The header is 21 bytes: D5 AA 96 FF FE, then track, sector and check (track XOR sector XOR 0xFE). Each of these three fields is sent as two bytes, ((v>>1)&0x55)|0xAA and then (v&0x55)|0xAA. The header ends with DE AA FF FF FF FF FF D5 AA AD.
- R7: Raw value i, for i from 0 to 85, holds bits 0 and 1 of source bytes (i+172) mod 256, (i+86) and i. They sit at bit positions 7/6, 5/4 and 3/2 respectively, with bit 0 placed in the higher position of each pair and bits 1:0 zero. Raw values 84 and 85 have bits 7:6 cleared. Raw values 86..341 are source bytes 0..255, and raw value 342 is 0.
- R8: Data byte k (0..342) is T[(raw[k] XOR raw[k-1]) >> 2], where raw[-1]=0. T is the 64-entry disk-byte table 96 97 9A 9B 9D 9E 9F A6 A7 AB AC AD AE AF B2 B3 B4 B5 B6 B7 B9 BA BB BC BD BE BF CB CD CE CF D3 D6 D7 D9 DA DB DC DD DE DF E5 E6 E7 E9 EA EB EC ED EE EF F2 F3 F4 F5 F6 F7 F9 FA FB FC FD FE FF, in index order.
- R9: After the data come 48 trailer bytes: DE AA EB FF EB and then 43 bytes of 0xFF. A sector is 412 bytes (476 with the gap). `busy` and `out_valid` fall in the cycle after the last byte is taken.
- R10: `logical_sec` equals the DOS interleave of `phys_sec`: for physical 0..15 it gives 0,7,14,6,13,5,12,4,11,3,10,2,9,1,8,15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Buffer byte write strobe (ignored while busy) |
| wr_addr | input | 8 | Buffer byte address |
| wr_data | input | 8 | Buffer byte value |
| start | input | 1 | Begin streaming one sector (ignored while busy) |
| with_gap | input | 1 | Prefix the 64-byte sync gap |
| track | input | 8 | Track number for the header |
| phys_sec | input | 4 | Physical sector number for the header and interleave lookup |
| logical_sec | output | 4 | DOS-order logical sector for `phys_sec` |
| busy | output | 1 | A stream is in progress |
| out_valid | output | 1 | Stream byte available |
| out_ready | input | 1 | Sink accepts the byte |
| out_data | output | 8 | Stream byte |

## Verification
Some properties are checked on every cycle. A stalled byte must stay stable. Every data-phase byte must have bit 7 set. A stream must start the cycle after an idle `start`. A `start` arriving while busy must leave the latched header fields alone. When `busy` falls, the count of accepted bytes must equal 412 or 476. Bit-exact content needs the bench's scenarios, which compare whole streams against an independent model: the 4-and-4 header fields, the auxiliary packing and wrap, the XOR chain with its closing checksum entry, the translate table and the trailer. The same comparisons show that writes made mid-stream do not leak into the output, and they cover the interleave lookup.

// File: rtl/nss_pkg.sv
package nss_pkg;

  typedef enum logic [1:0] {PH_GAP, PH_HDR, PH_DAT, PH_EPI} phase_e;

  localparam logic [7:0] DISK_CODE [64] = '{
    8'h96, 8'h97, 8'h9A, 8'h9B, 8'h9D, 8'h9E, 8'h9F, 8'hA6,
    8'hA7, 8'hAB, 8'hAC, 8'hAD, 8'hAE, 8'hAF, 8'hB2, 8'hB3,
    8'hB4, 8'hB5, 8'hB6, 8'hB7, 8'hB9, 8'hBA, 8'hBB, 8'hBC,
    8'hBD, 8'hBE, 8'hBF, 8'hCB, 8'hCD, 8'hCE, 8'hCF, 8'hD3,
    8'hD6, 8'hD7, 8'hD9, 8'hDA, 8'hDB, 8'hDC, 8'hDD, 8'hDE,
    8'hDF, 8'hE5, 8'hE6, 8'hE7, 8'hE9, 8'hEA, 8'hEB, 8'hEC,
    8'hED, 8'hEE, 8'hEF, 8'hF2, 8'hF3, 8'hF4, 8'hF5, 8'hF6,
    8'hF7, 8'hF9, 8'hFA, 8'hFB, 8'hFC, 8'hFD, 8'hFE, 8'hFF};

  localparam logic [3:0] DOS_SKEW [16] = '{
    4'h0, 4'h7, 4'hE, 4'h6, 4'hD, 4'h5, 4'hC, 4'h4,
    4'hB, 4'h3, 4'hA, 4'h2, 4'h9, 4'h1, 4'h8, 4'hF};

  function automatic logic [7:0] odd_half(input logic [7:0] v);
    return ((v >> 1) & 8'h55) | 8'hAA;
  endfunction

  function automatic logic [7:0] even_half(input logic [7:0] v);
    return (v & 8'h55) | 8'hAA;
  endfunction

endpackage

// File: rtl/nss_sector_buf.sv
module nss_sector_buf #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd0,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
  assign rd2 = mem[ra2];
endmodule

// File: rtl/nss_six_two.sv
module nss_six_two
  import nss_pkg::*;
#(
  parameter int AUX_N = 86,
  parameter int SRC_N = 256,
  localparam int AW   = $clog2(SRC_N),
  localparam int DAT_N = AUX_N + SRC_N + 1,
  localparam int IW   = $clog2(DAT_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          adv,
  input  logic [IW-1:0] idx,
  output logic [AW-1:0] ra0,
  output logic [AW-1:0] ra1,
  output logic [AW-1:0] ra2,
  input  logic [7:0]    rd0,
  input  logic [7:0]    rd1,
  input  logic [7:0]    rd2,
  output logic [7:0]    code
);
  logic [7:0]    prev_q, raw, chained;
  logic [IW-1:0] src_i, mid_i, hi_i;

  assign src_i = idx - IW'(AUX_N);
  assign mid_i = idx + IW'(AUX_N);
  assign hi_i  = idx + IW'(2 * AUX_N);

  // port 0 doubles as the straight source read past the auxiliary block
  assign ra0 = (idx < IW'(AUX_N)) ? idx[AW-1:0] : src_i[AW-1:0];
  assign ra1 = mid_i[AW-1:0];
  assign ra2 = hi_i[AW-1:0];

  always_comb begin
    if (idx < IW'(AUX_N)) begin
      raw = {rd2[0], rd2[1], rd1[0], rd1[1], rd0[0], rd0[1], 2'b00};
      if (idx >= IW'(AUX_N - 2)) raw[7:6] = 2'b00;
    end else if (idx < IW'(AUX_N + SRC_N)) begin
      raw = rd0;
    end else begin
      raw = 8'h00;
    end
    chained = raw ^ prev_q;
    code    = DISK_CODE[chained[7:2]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) prev_q <= 8'h00;
    else if (adv)        prev_q <= raw;
  end
endmodule

// File: rtl/nss_frame_ctrl.sv
module nss_frame_ctrl
  import nss_pkg::*;
#(
  parameter int GAP_N = 64,
  parameter int HDR_N = 21,
  parameter int DAT_N = 343,
  parameter int EPI_N = 48,
  localparam int SECTOR_N = HDR_N + DAT_N + EPI_N,
  localparam int CW   = $clog2(DAT_N),
  localparam int EW   = $clog2(GAP_N + SECTOR_N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          with_gap,
  input  logic [7:0]    track,
  input  logic [3:0]    phys_sec,
  input  logic          out_ready,
  input  logic [7:0]    code,
  output logic          busy,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic [CW-1:0] dat_idx,
  output logic          dat_adv,
  output logic          clear
);
  phase_e        phase_q;
  logic          busy_q, fire, accept;
  logic [CW-1:0] cnt_q, lim;
  logic [7:0]    trk_q, sec_q, chk;

  assign accept    = start && !busy_q;
  assign fire      = busy_q && out_ready;
  assign busy      = busy_q;
  assign out_valid = busy_q;
  assign clear     = accept;
  assign dat_idx   = cnt_q;
  assign dat_adv   = fire && (phase_q == PH_DAT);
  assign chk       = trk_q ^ sec_q ^ 8'hFE;

  always_comb begin
    unique case (phase_q)
      PH_GAP:  lim = CW'(GAP_N - 1);
      PH_HDR:  lim = CW'(HDR_N - 1);
      PH_DAT:  lim = CW'(DAT_N - 1);
      default: lim = CW'(EPI_N - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= PH_GAP;
      cnt_q   <= '0;
      trk_q   <= 8'h00;
      sec_q   <= 8'h00;
    end else if (accept) begin
      busy_q  <= 1'b1;
      phase_q <= with_gap ? PH_GAP : PH_HDR;
      cnt_q   <= '0;
      trk_q   <= track;
      sec_q   <= {4'h0, phys_sec};
    end else if (fire) begin
      if (cnt_q == lim) begin
        cnt_q <= '0;
        unique case (phase_q)
          PH_GAP:  phase_q <= PH_HDR;
          PH_HDR:  phase_q <= PH_DAT;
          PH_DAT:  phase_q <= PH_EPI;
          default: begin
            phase_q <= PH_GAP;
            busy_q  <= 1'b0;
          end
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    out_data = 8'hFF;
    unique case (phase_q)
      PH_GAP: out_data = 8'hFF;
      PH_HDR: begin
        case (cnt_q)
          CW'(0):  out_data = 8'hD5;
          CW'(1):  out_data = 8'hAA;
          CW'(2):  out_data = 8'h96;
          CW'(4):  out_data = 8'hFE;
          CW'(5):  out_data = odd_half(trk_q);
          CW'(6):  out_data = even_half(trk_q);
          CW'(7):  out_data = odd_half(sec_q);
          CW'(8):  out_data = even_half(sec_q);
          CW'(9):  out_data = odd_half(chk);
          CW'(10): out_data = even_half(chk);
          CW'(11): out_data = 8'hDE;
          CW'(12): out_data = 8'hAA;
          CW'(18): out_data = 8'hD5;
          CW'(19): out_data = 8'hAA;
          CW'(20): out_data = 8'hAD;
          default: out_data = 8'hFF;
        endcase
      end
      PH_DAT: out_data = code;
      default: begin
        case (cnt_q)
          CW'(0):  out_data = 8'hDE;
          CW'(1):  out_data = 8'hAA;
          CW'(2):  out_data = 8'hEB;
          CW'(4):  out_data = 8'hEB;
          default: out_data = 8'hFF;
        endcase
      end
    endcase
  end

  // byte counter kept only for the length property below
  logic [EW-1:0] emitted_q;
  logic          gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emitted_q <= '0;
      gap_q     <= 1'b0;
    end else if (accept) begin
      emitted_q <= '0;
      gap_q     <= with_gap;
    end else if (fire) begin
      emitted_q <= emitted_q + 1'b1;
    end
  end

  assert_frame_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> emitted_q == (gap_q ? EW'(GAP_N + SECTOR_N) : EW'(SECTOR_N)));

  assert_start_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> (busy_q && cnt_q == '0 && (phase_q == PH_GAP || phase_q == PH_HDR)));

  assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy_q) |=> ($stable(trk_q) && $stable(sec_q)));

  assert_data_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && phase_q == PH_DAT) |-> out_data[7]);
endmodule

// File: rtl/nib_sector_stream.sv
module nib_sector_stream
  import nss_pkg::*;
#(
  parameter int SRC_N = 256,
  parameter int AUX_N = 86,
  parameter int GAP_N = 64,
  parameter int HDR_N = 21,
  parameter int EPI_N = 48,
  localparam int AW   = $clog2(SRC_N),
  localparam int DAT_N = AUX_N + SRC_N + 1,
  localparam int CW   = $clog2(DAT_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          start,
  input  logic          with_gap,
  input  logic [7:0]    track,
  input  logic [3:0]    phys_sec,
  output logic [3:0]    logical_sec,
  output logic          busy,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data
);
  logic [AW-1:0] ra0, ra1, ra2;
  logic [7:0]    rd0, rd1, rd2, code;
  logic [CW-1:0] dat_idx;
  logic          dat_adv, clear;

  assign logical_sec = DOS_SKEW[phys_sec];

  nss_sector_buf #(.DEPTH(SRC_N), .W(8)) u_buf (
    .clk(clk), .we(wr_en && !busy), .waddr(wr_addr), .wdata(wr_data),
    .ra0(ra0), .ra1(ra1), .ra2(ra2), .rd0(rd0), .rd1(rd1), .rd2(rd2));

  nss_six_two #(.AUX_N(AUX_N), .SRC_N(SRC_N)) u_enc (
    .clk(clk), .rst_n(rst_n), .clear(clear), .adv(dat_adv), .idx(dat_idx),
    .ra0(ra0), .ra1(ra1), .ra2(ra2), .rd0(rd0), .rd1(rd1), .rd2(rd2),
    .code(code));

  nss_frame_ctrl #(.GAP_N(GAP_N), .HDR_N(HDR_N), .DAT_N(DAT_N), .EPI_N(EPI_N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .with_gap(with_gap),
    .track(track), .phys_sec(phys_sec), .out_ready(out_ready), .code(code),
    .busy(busy), .out_valid(out_valid), .out_data(out_data),
    .dat_idx(dat_idx), .dat_adv(dat_adv), .clear(clear));

  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/tb_nib_sector_stream.sv
`timescale 1ns/1ps
module tb_nib_sector_stream;
  localparam logic [7:0] TBL [64] = '{
    8'h96, 8'h97, 8'h9A, 8'h9B, 8'h9D, 8'h9E, 8'h9F, 8'hA6,
    8'hA7, 8'hAB, 8'hAC, 8'hAD, 8'hAE, 8'hAF, 8'hB2, 8'hB3,
    8'hB4, 8'hB5, 8'hB6, 8'hB7, 8'hB9, 8'hBA, 8'hBB, 8'hBC,
    8'hBD, 8'hBE, 8'hBF, 8'hCB, 8'hCD, 8'hCE, 8'hCF, 8'hD3,
    8'hD6, 8'hD7, 8'hD9, 8'hDA, 8'hDB, 8'hDC, 8'hDD, 8'hDE,
    8'hDF, 8'hE5, 8'hE6, 8'hE7, 8'hE9, 8'hEA, 8'hEB, 8'hEC,
    8'hED, 8'hEE, 8'hEF, 8'hF2, 8'hF3, 8'hF4, 8'hF5, 8'hF6,
    8'hF7, 8'hF9, 8'hFA, 8'hFB, 8'hFC, 8'hFD, 8'hFE, 8'hFF};
  // interleave vectors: {physical, expected logical}
  localparam logic [7:0] SKEW_VEC [16] = '{
    8'h00, 8'h17, 8'h2E, 8'h36, 8'h4D, 8'h55, 8'h6C, 8'h74,
    8'h8B, 8'h93, 8'hAA, 8'hB2, 8'hC9, 8'hD1, 8'hE8, 8'hFF};

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0, with_gap = 0, out_ready = 0;
  logic [7:0] wr_addr = 0, wr_data = 0, track = 0;
  logic [3:0] phys_sec = 0;
  logic [3:0] logical_sec;
  logic busy, out_valid;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  nib_sector_stream dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .with_gap(with_gap), .track(track), .phys_sec(phys_sec),
    .logical_sec(logical_sec), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  int n_chk = 0, n_bad = 0;
  logic [7:0] src [256];
  logic [7:0] expv [476];
  logic [7:0] got [600];
  int exp_len, got_len, data_base;
  bit stall_bad, started_ok;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expd);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expd);
    end
  endtask

  function automatic logic [7:0] oddh(input logic [7:0] v); return ((v >> 1) & 8'h55) | 8'hAA; endfunction
  function automatic logic [7:0] evnh(input logic [7:0] v); return (v & 8'h55) | 8'hAA; endfunction

  task automatic build_expected(input logic [7:0] trk, input logic [7:0] sec, input bit gap);
    logic [7:0] raw [343];
    logic [7:0] hdr [21];
    logic [7:0] ck, a, b, c, pv;
    int k;
    k = 0;
    if (gap) for (int i = 0; i < 64; i++) begin expv[k] = 8'hFF; k++; end
    ck = trk ^ sec ^ 8'hFE;
    hdr = '{8'hD5, 8'hAA, 8'h96, 8'hFF, 8'hFE, oddh(trk), evnh(trk), oddh(sec), evnh(sec),
            oddh(ck), evnh(ck), 8'hDE, 8'hAA, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
            8'hD5, 8'hAA, 8'hAD};
    for (int i = 0; i < 21; i++) begin expv[k] = hdr[i]; k++; end
    data_base = k;
    for (int i = 0; i < 86; i++) begin
      a = src[(i + 172) % 256]; b = src[i + 86]; c = src[i];
      raw[i] = {a[0], a[1], b[0], b[1], c[0], c[1], 2'b00};
      if (i >= 84) raw[i] = raw[i] & 8'h3F;
    end
    for (int i = 0; i < 256; i++) raw[86 + i] = src[i];
    raw[342] = 8'h00;
    pv = 8'h00;
    for (int i = 0; i < 343; i++) begin
      expv[k] = TBL[(raw[i] ^ pv) >> 2];
      pv = raw[i];
      k++;
    end
    for (int i = 0; i < 48; i++) begin
      expv[k] = (i == 0) ? 8'hDE : (i == 1) ? 8'hAA : (i == 2 || i == 4) ? 8'hEB : 8'hFF;
      k++;
    end
    exp_len = k;
  endtask

  task automatic load_src();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      wr_en = 1; wr_addr = 8'(i); wr_data = src[i];
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run_stream(input logic [7:0] trk, input logic [3:0] sec, input bit gap,
                            input int mode, input bit poke);
    bit prev_stall, poked;
    logic [7:0] prev_d;
    int cyc;
    got_len = 0; stall_bad = 0; prev_stall = 0; poked = 0; prev_d = 0; cyc = 0;
    @(negedge clk);
    start = 1; track = trk; phys_sec = sec; with_gap = gap; out_ready = 0;
    @(negedge clk);
    start = 0;
    started_ok = out_valid && busy;
    while (cyc < 5000) begin
      if (poke && !poked && got_len == 100) begin
        wr_en = 1; wr_addr = 8'h00; wr_data = ~src[0];
        start = 1; track = 8'h63; phys_sec = 4'h3; with_gap = !gap;
        poked = 1;
      end else begin
        wr_en = 0; start = 0;
      end
      out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 3 != 0) : (cyc % 7 < 3);
      if (!out_valid) break;
      if (prev_stall && out_data !== prev_d) stall_bad = 1;
      if (out_ready) begin
        if (got_len < 600) got[got_len] = out_data;
        got_len++;
      end
      prev_stall = !out_ready;
      prev_d = out_data;
      cyc++;
      @(negedge clk);
    end
    wr_en = 0; start = 0; out_ready = 0;
  endtask

  task automatic compare_stream(input string tag);
    int bad_hdr, bad_dat, bad_epi, fh, fd, fe;
    bad_hdr = -1; bad_dat = -1; bad_epi = -1; fh = 0; fd = 0; fe = 0;
    chk(started_ok, "R2", {tag, " valid+busy the cycle after start"}, started_ok, 1);
    chk(got_len == exp_len, "R9", {tag, " stream length"}, got_len, exp_len);
    chk(!stall_bad, "R4", {tag, " byte held while stalled"}, stall_bad, 0);
    for (int i = 0; i < exp_len && i < got_len; i++) begin
      if (got[i] !== expv[i]) begin
        if (i < data_base) begin if (bad_hdr < 0) begin bad_hdr = i; fh = got[i]; end end
        else if (i < data_base + 343) begin if (bad_dat < 0) begin bad_dat = i; fd = got[i]; end end
        else if (bad_epi < 0) begin bad_epi = i; fe = got[i]; end
      end
    end
    chk(bad_hdr < 0, "R5/R6", {tag, " gap and header bytes"}, fh, (bad_hdr < 0) ? 0 : int'(expv[bad_hdr]));
    chk(bad_dat < 0, "R7/R8", {tag, " translated data bytes"}, fd, (bad_dat < 0) ? 0 : int'(expv[bad_dat]));
    chk(bad_epi < 0, "R9", {tag, " trailer bytes"}, fe, (bad_epi < 0) ? 0 : int'(expv[bad_epi]));
    chk(!busy && !out_valid, "R9", {tag, " idle after last byte"}, {busy, out_valid}, 0);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", wd);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && out_valid == 0, "R1", "reset idle", {busy, out_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && out_valid == 0, "R1", "idle after reset release", {busy, out_valid}, 0);

    // R10 interleave vectors
    for (int i = 0; i < 16; i++) begin
      phys_sec = SKEW_VEC[i][7:4];
      #1;
      chk(logical_sec == SKEW_VEC[i][3:0], "R10", "DOS interleave", logical_sec, SKEW_VEC[i][3:0]);
    end

    // pattern A, gap, free-running sink
    for (int i = 0; i < 256; i++) src[i] = 8'(i * 37 + 11);
    load_src();
    build_expected(8'd17, 8'd5, 1);
    run_stream(8'd17, 4'd5, 1, 0, 0);
    compare_stream("patA gap");

    // R3: writes and start during stream ignored, R4 with stalls
    build_expected(8'd2, 8'd0, 0);
    run_stream(8'd2, 4'd0, 0, 1, 1);
    compare_stream("R3 poke during stream");
    // re-stream: src[0] write during busy must not have landed
    build_expected(8'd2, 8'd0, 0);
    run_stream(8'd2, 4'd0, 0, 0, 0);
    compare_stream("R3 buffer unchanged");

    // all zeros, last track and sector, bursty sink
    for (int i = 0; i < 256; i++) src[i] = 8'h00;
    load_src();
    build_expected(8'd34, 8'd15, 1);
    run_stream(8'd34, 4'd15, 1, 2, 0);
    compare_stream("zeros t34 s15");
    chk(got[64 + 21] == 8'h96, "R8", "zero data maps to first table entry", got[85], 8'h96);

    // all ones, track 0 sector 0: check bytes encode 0xFE
    for (int i = 0; i < 256; i++) src[i] = 8'hFF;
    load_src();
    build_expected(8'd0, 8'd0, 0);
    run_stream(8'd0, 4'd0, 0, 1, 0);
    compare_stream("ones t0 s0");
    chk(got[9] == 8'hFF && got[10] == 8'hFE, "R6", "checksum field t0 s0",
        {got[9], got[10]}, 16'hFFFE);
    chk(got[0] == 8'hD5, "R5", "no gap: first byte is header", got[0], 8'hD5);

    // mixed bit pattern exercising the auxiliary wrap and masking (R7)
    for (int i = 0; i < 256; i++) src[i] = 8'(i ^ (i >> 3) ^ 8'h5A);
    load_src();
    build_expected(8'd1, 8'd9, 1);
    run_stream(8'd1, 4'd9, 1, 2, 0);
    compare_stream("mixed R7");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule